// File: doc/BRIEF.md
# Serial Bulk-Erase Programming Sequencer

This block sits on the host side of a two-wire serial programming link. It drives a programming clock and a data line toward a target microcontroller. A single start pulse makes it replay a fixed script of fifteen transfers that wipes the target's whole flash.

Each transfer is a 4-bit command code followed by a 16-bit payload. The script has three parts:

- It loads the target's three-byte table pointer with core-instruction transfers.
- It writes two table words that together request the erase.
- It finishes with a no-operation transfer.

The falling edge of the fourth command clock of that final transfer starts the erase inside the target. From then on the sequencer keeps the data line low and waits out a self-timed erase interval. It then drops its busy flag and pulses done for one cycle.

All timing is counted in system-clock cycles and set by parameters:

- the programming clock half-period;
- the pause between a command and its payload;
- the pause between a payload and the next command;
- the erase wait.

Top module: `bulk_erase_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in idle with busy_o=0, done_o=0, prog_clk_o=0 and prog_data_o=0, including when it arrives in the middle of a run; after it the programming clock stays low until a new start.
- R2: A start_i pulse sampled in idle begins a run. busy_o is 1 from the next clock edge until the edge at which done_o rises, and the first programming clock rising edge happens at that same next edge.
- R3: A run consists of exactly 15 transfers. Each transfer is 4 command bits followed by 16 payload bits, both fields least-significant bit first. A new bit value appears on prog_data_o at a prog_clk_o rising edge and stays unchanged until the following falling edge, where the target samples it.
- R4: The command and payload of each transfer, in order, are as follows. Command 0000 means core instruction and command 1100 means table write.
  - Transfers 0 to 5: core instructions with payloads 0E3C, 6EF8, 0E00, 6EF7, 0E05, 6EF6.
  - Transfer 6: table write with payload 0101.
  - Transfers 7 to 12: core instructions with payloads 0E3C, 6EF8, 0E00, 6EF7, 0E04, 6EF6.
  - Transfer 13: table write with payload 8080.
  - Transfer 14: command 0000 with payload 0000 (a no-operation).
- R5: Within a field, prog_clk_o is high for HALF_PERIOD cycles per bit and low for HALF_PERIOD cycles between bits.
- R6: Between the falling edge of a command's last bit and the rising edge of its payload's first bit, prog_clk_o stays low for HALF_PERIOD+CMD_PAY_GAP cycles.
- R7: Between the falling edge of a payload's last bit and the rising edge of the next command's first bit, prog_clk_o stays low for HALF_PERIOD+PAY_CMD_GAP cycles.
- R8: The erase starts at the falling edge of the fourth command bit of transfer 14. From that edge until done_o, prog_data_o stays 0. After the zero payload of transfer 14, prog_clk_o stays low.
- R9: Let E be the erase-start edge. done_o is high for exactly one cycle, starting at edge E + max(ERASE_WAIT, 33*HALF_PERIOD+CMD_PAY_GAP). busy_o falls at that same edge.
- R10: A start_i pulse while busy_o=1 has no effect. The run still produces exactly 15 transfers and one done pulse, and no further activity follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled in idle only |
| prog_clk_o | output | 1 | Programming clock toward the target |
| prog_data_o | output | 1 | Programming data driven toward the target |
| busy_o | output | 1 | High while a bulk-erase run is in progress |
| done_o | output | 1 | One-cycle pulse when the erase wait has ended |

## Verification
Two events can land in the same system cycle:

- the erase timer running out;
- the last bit of the final no-operation payload finishing.

The sequencer must then finish directly from the payload state rather than pass through the wait state.

The bench provokes this with a second instance whose erase wait equals exactly the duration of that payload, 33 half-periods plus the command-to-payload pause. It judges the result by measuring, from the outputs alone, the distance from the erase-start falling edge to the done pulse. It also counts that exactly one done pulse appears. The default instance, whose wait is much longer, sees the two events far apart.

// File: rtl/bes_pkg.sv
package bes_pkg;

    localparam int CMD_BITS = 4;
    localparam int PAY_BITS = 16;
    localparam int N_STEPS  = 15;
    localparam int STEP_W   = 4;

    localparam logic [CMD_BITS-1:0] CODE_CORE  = 4'b0000;
    localparam logic [CMD_BITS-1:0] CODE_TBLWR = 4'b1100;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_GAP_A,
        S_PAY,
        S_GAP_B,
        S_TAIL
    } seq_state_e;

    typedef struct packed {
        logic [CMD_BITS-1:0] code;
        logic [PAY_BITS-1:0] word;
    } xfer_t;

    // Two pointer-load groups of seven steps each, then the closing no-op.
    function automatic xfer_t script_step(input logic [STEP_W-1:0] idx);
        xfer_t       x;
        logic [3:0]  sub;
        logic        grp;
        logic [7:0]  lit;
        x.code = CODE_CORE;
        x.word = '0;
        sub    = '0;
        grp    = 1'b0;
        lit    = '0;
        if (idx < 4'd14) begin
            grp = (idx >= 4'd7);
            sub = grp ? (idx - 4'd7) : idx;
            if (sub == 4'd6) begin
                x.code = CODE_TBLWR;
                x.word = grp ? 16'h8080 : 16'h0101;
            end else begin
                case (sub[2:1])
                    2'd0:    lit = 8'h3C;
                    2'd1:    lit = 8'h00;
                    default: lit = grp ? 8'h04 : 8'h05;
                endcase
                if (sub[0])
                    x.word = {8'h6E, 8'hF8 - {6'b0, sub[2:1]}};
                else
                    x.word = {8'h0E, lit};
            end
        end
        return x;
    endfunction

endpackage

// File: rtl/bes_shifter.sv
module bes_shifter #(
    parameter int HALF = 2,
    parameter int WMAX = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_i,
    input  logic [$clog2(WMAX+1)-1:0]  nbits_i,
    input  logic [WMAX-1:0]            word_i,
    output logic                       sclk_o,
    output logic                       sdat_o,
    output logic                       fall_last_o,
    output logic                       done_o
);
    localparam int HW  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int IW  = $clog2(WMAX);
    localparam int NBW = $clog2(WMAX+1);

    logic [WMAX-1:0] word_q;
    logic [NBW-1:0]  nb_q;
    logic [IW-1:0]   idx_q;
    logic [IW-1:0]   idx_nxt;
    logic [HW-1:0]   cnt_q;
    logic            hi_q;
    logic            busy_q;
    logic            sclk_q;
    logic            sdat_q;
    logic            at_end;
    logic            last_bit;

    assign idx_nxt     = idx_q + 1'b1;
    assign at_end      = busy_q && (cnt_q == '0);
    assign last_bit    = (NBW'(idx_q) == (nb_q - NBW'(1)));
    assign fall_last_o = at_end && hi_q && last_bit;
    assign done_o      = at_end && !hi_q && last_bit;
    assign sclk_o      = sclk_q;
    assign sdat_o      = sdat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            nb_q   <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
            hi_q   <= 1'b0;
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            sdat_q <= 1'b0;
        end else if (!busy_q) begin
            if (load_i) begin
                busy_q <= 1'b1;
                word_q <= word_i;
                nb_q   <= nbits_i;
                idx_q  <= '0;
                hi_q   <= 1'b1;
                sclk_q <= 1'b1;
                sdat_q <= word_i[0];
                cnt_q  <= HW'(HALF-1);
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (hi_q) begin
            sclk_q <= 1'b0;
            hi_q   <= 1'b0;
            cnt_q  <= HW'(HALF-1);
        end else if (last_bit) begin
            busy_q <= 1'b0;
            sdat_q <= 1'b0;
        end else begin
            idx_q  <= idx_nxt;
            hi_q   <= 1'b1;
            sclk_q <= 1'b1;
            sdat_q <= word_q[idx_nxt];
            cnt_q  <= HW'(HALF-1);
        end
    end

    // R3: data only moves at a rising edge, never while the clock is high
    p_data_stable_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (sclk_q && $past(sclk_q)) |-> $stable(sdat_q));

    // R1: with no field in flight the programming clock rests low
    p_idle_clk_low_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !sclk_q);

endmodule

// File: rtl/bes_erase_timer.sv
module bes_erase_timer #(
    parameter int WAIT = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic done_o
);
    localparam int TW = (WAIT > 1) ? $clog2(WAIT) : 1;

    logic [TW-1:0] cnt_q;
    logic          run_q;
    logic          exp_q;

    assign done_o = exp_q || (run_q && (cnt_q == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            exp_q <= 1'b0;
        end else if (start_i) begin
            cnt_q <= TW'(WAIT-1);
            run_q <= 1'b1;
            exp_q <= 1'b0;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
                exp_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R9: once expired the timer stays expired until the next erase start
    p_expiry_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

endmodule

// File: rtl/bulk_erase_seq.sv
module bulk_erase_seq
    import bes_pkg::*;
#(
    parameter int HALF_PERIOD = 2,
    parameter int CMD_PAY_GAP = 3,
    parameter int PAY_CMD_GAP = 5,
    parameter int ERASE_WAIT  = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic prog_clk_o,
    output logic prog_data_o,
    output logic busy_o,
    output logic done_o
);
    localparam int NBW  = $clog2(PAY_BITS+1);
    localparam int GMAX = (CMD_PAY_GAP > PAY_CMD_GAP) ? CMD_PAY_GAP : PAY_CMD_GAP;
    localparam int GW   = (GMAX > 1) ? $clog2(GMAX) : 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS-1);

    seq_state_e          st_q;
    logic [STEP_W-1:0]   step_q;
    logic [GW-1:0]       gcnt_q;
    logic                busy_q;
    logic                done_q;
    xfer_t               cur;
    logic                is_last;

    logic                sh_load;
    logic [NBW-1:0]      sh_nbits;
    logic [PAY_BITS-1:0] sh_word;
    logic                sh_sclk;
    logic                sh_sdat;
    logic                sh_fall_last;
    logic                sh_done;
    logic                erase_go;
    logic                tmr_done;

    assign cur     = script_step(step_q);
    assign is_last = (step_q == LAST_STEP);

    always_comb begin
        sh_load  = 1'b0;
        sh_nbits = NBW'(CMD_BITS);
        sh_word  = {{(PAY_BITS-CMD_BITS){1'b0}}, cur.code};
        case (st_q)
            S_IDLE:  sh_load = start_i;
            S_GAP_A: begin
                sh_load  = (gcnt_q == '0);
                sh_nbits = NBW'(PAY_BITS);
                sh_word  = cur.word;
            end
            S_GAP_B: sh_load = (gcnt_q == '0);
            default: sh_load = 1'b0;
        endcase
    end

    assign erase_go = (st_q == S_CMD) && is_last && sh_fall_last;

    bes_shifter #(
        .HALF (HALF_PERIOD),
        .WMAX (PAY_BITS)
    ) u_shift (
        .clk         (clk),
        .rst         (rst),
        .load_i      (sh_load),
        .nbits_i     (sh_nbits),
        .word_i      (sh_word),
        .sclk_o      (sh_sclk),
        .sdat_o      (sh_sdat),
        .fall_last_o (sh_fall_last),
        .done_o      (sh_done)
    );

    bes_erase_timer #(
        .WAIT (ERASE_WAIT)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (erase_go),
        .done_o  (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            step_q <= '0;
            gcnt_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                S_IDLE: begin
                    if (start_i) begin
                        st_q   <= S_CMD;
                        busy_q <= 1'b1;
                    end
                end
                S_CMD: begin
                    if (sh_done) begin
                        st_q   <= S_GAP_A;
                        gcnt_q <= GW'(CMD_PAY_GAP-1);
                    end
                end
                S_GAP_A: begin
                    if (gcnt_q == '0) st_q <= S_PAY;
                    else              gcnt_q <= gcnt_q - 1'b1;
                end
                S_PAY: begin
                    if (sh_done) begin
                        if (is_last) begin
                            if (tmr_done) begin
                                st_q   <= S_IDLE;
                                busy_q <= 1'b0;
                                done_q <= 1'b1;
                                step_q <= '0;
                            end else begin
                                st_q <= S_TAIL;
                            end
                        end else begin
                            step_q <= step_q + 1'b1;
                            st_q   <= S_GAP_B;
                            gcnt_q <= GW'(PAY_CMD_GAP-1);
                        end
                    end
                end
                S_GAP_B: begin
                    if (gcnt_q == '0) st_q <= S_CMD;
                    else              gcnt_q <= gcnt_q - 1'b1;
                end
                S_TAIL: begin
                    if (tmr_done) begin
                        st_q   <= S_IDLE;
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        step_q <= '0;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign prog_clk_o  = sh_sclk;
    assign prog_data_o = sh_sdat;
    assign busy_o      = busy_q;
    assign done_o      = done_q;

    // R9: the done pulse never overlaps busy
    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R9: done rises only after the erase timer has reported expiry
    p_done_after_wait_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(tmr_done));

    // R8: while waiting out the erase the link is quiet and data is low
    p_tail_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_TAIL) |-> (!prog_data_o && !prog_clk_o));

    // R10: a start seen mid-run never rewinds the script
    p_no_rewind_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> (step_q >= $past(step_q)));

endmodule

// File: tb/bulk_erase_seq_tb.sv
module bulk_erase_seq_tb;

    localparam int HALF = 2;
    localparam int P5   = 3;
    localparam int P5A  = 5;
    localparam int P11  = 400;
    localparam int P11B = 33*HALF + P5;
    localparam int NBIT = 300;
    localparam int EIDX = 283;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic pclk, pdat, busy, done;
    logic pclk_b, pdat_b, busy_b, done_b;

    always #4 clk = ~clk;

    bulk_erase_seq #(.HALF_PERIOD(HALF), .CMD_PAY_GAP(P5), .PAY_CMD_GAP(P5A),
                     .ERASE_WAIT(P11)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .prog_clk_o(pclk),
        .prog_data_o(pdat), .busy_o(busy), .done_o(done));

    bulk_erase_seq #(.HALF_PERIOD(HALF), .CMD_PAY_GAP(P5), .PAY_CMD_GAP(P5A),
                     .ERASE_WAIT(P11B)) u_dut_b (
        .clk(clk), .rst(rst), .start_i(start), .prog_clk_o(pclk_b),
        .prog_data_o(pdat_b), .busy_o(busy_b), .done_o(done_b));

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    logic [3:0]  exp_code [15];
    logic [15:0] exp_word [15];

    // monitor state for instance A
    int  nfall, nrise, last_fall, rise_cyc, e_cyc, d_cyc, done_cnt;
    int  lobit_err, lo5_err, lo5a_err, hi_err, stab_err, erase_err, busy_err;
    logic prev_clk, hold_dat, prev_busy;
    logic cap [NBIT];
    // monitor state for instance B
    int  nfall_b, e_cyc_b, d_cyc_b, done_cnt_b;
    logic prev_clk_b;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic clear_mon();
        nfall = 0; nrise = 0; last_fall = 0; rise_cyc = 0; e_cyc = -1; d_cyc = -1;
        done_cnt = 0; lobit_err = 0; lo5_err = 0; lo5a_err = 0; hi_err = 0;
        stab_err = 0; erase_err = 0; busy_err = 0;
        prev_clk = pclk; hold_dat = 1'b0; prev_busy = busy;
        for (int i = 0; i < NBIT; i++) cap[i] = 1'b0;
        nfall_b = 0; e_cyc_b = -1; d_cyc_b = -1; done_cnt_b = 0; prev_clk_b = pclk_b;
    endtask

    always @(negedge clk) begin
        if (!prev_clk && pclk) begin
            if (nrise > 0) begin
                if (nrise % 20 == 4) begin
                    if (cyc - last_fall != HALF + P5) lo5_err++;
                end else if (nrise % 20 == 0) begin
                    if (cyc - last_fall != HALF + P5A) lo5a_err++;
                end else if (cyc - last_fall != HALF) lobit_err++;
            end
            rise_cyc = cyc;
            hold_dat = pdat;
            nrise++;
        end
        if (prev_clk && pclk && (pdat !== hold_dat)) stab_err++;
        if (prev_clk && !pclk) begin
            if (cyc - rise_cyc != HALF) hi_err++;
            if (nfall < NBIT) cap[nfall] = pdat;
            if (nfall == EIDX) e_cyc = cyc;
            nfall++;
            last_fall = cyc;
        end
        if (e_cyc >= 0 && cyc > e_cyc && done_cnt == 0 && pdat) erase_err++;
        if (done) begin
            done_cnt++;
            d_cyc = cyc;
            if (busy || !prev_busy) busy_err++;
        end
        prev_busy = busy;
        prev_clk  = pclk;
        if (prev_clk_b && !pclk_b) begin
            if (nfall_b == EIDX) e_cyc_b = cyc;
            nfall_b++;
        end
        if (done_b) begin
            done_cnt_b++;
            d_cyc_b = cyc;
        end
        prev_clk_b = pclk_b;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 6000 && done_cnt == 0; i++) @(posedge clk);
    endtask

    task automatic check_script(input string tag);
        int bad_c;
        int bad_w;
        logic [3:0]  c;
        logic [15:0] w;
        bad_c = 0;
        bad_w = 0;
        for (int t = 0; t < 15; t++) begin
            for (int i = 0; i < 4; i++)  c[i] = cap[t*20 + i];
            for (int i = 0; i < 16; i++) w[i] = cap[t*20 + 4 + i];
            if (c !== exp_code[t]) begin
                bad_c++;
                $display("  transfer %0d command %b expected %b", t, c, exp_code[t]);
            end
            if (w !== exp_word[t]) begin
                bad_w++;
                $display("  transfer %0d payload %h expected %h", t, w, exp_word[t]);
            end
        end
        chk(bad_c == 0, {tag, " R4 command codes"}, bad_c, 0);
        chk(bad_w == 0, {tag, " R4 payload words"}, bad_w, 0);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
        chk(!pclk && !pdat, "R1 clock/data after reset", {pclk, pdat}, 0);
    endtask

    task automatic t_full_run();
        clear_mon();
        pulse_start();
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        chk(pclk == 1'b1, "R2 first clock rise at start edge", pclk, 1);
        wait_done();
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk(nrise == NBIT, "R3 total clock rises", nrise, NBIT);
        chk(nfall == NBIT, "R3 total clock falls", nfall, NBIT);
        chk(stab_err == 0, "R3 data stable while clock high", stab_err, 0);
        check_script("full");
        chk(hi_err == 0 && lobit_err == 0, "R5 bit high/low widths", hi_err + lobit_err, 0);
        chk(lo5_err == 0, "R6 command-to-payload low time", lo5_err, 0);
        chk(lo5a_err == 0, "R7 payload-to-command low time", lo5a_err, 0);
        chk(erase_err == 0, "R8 data low during erase", erase_err, 0);
        chk(!pclk && !pdat, "R8 link quiet after run", {pclk, pdat}, 0);
        chk(d_cyc - e_cyc == P11, "R9 erase start to done", d_cyc - e_cyc, P11);
        chk(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
        chk(busy_err == 0 && !busy, "R9 busy falls with done", busy_err, 0);
        chk(d_cyc_b - e_cyc_b == P11B, "R9 coincident expiry and payload end",
            d_cyc_b - e_cyc_b, P11B);
        chk(done_cnt_b == 1, "R9 coincident case single done", done_cnt_b, 1);
    endtask

    task automatic t_start_ignored();
        clear_mon();
        pulse_start();
        repeat (200) @(posedge clk);
        pulse_start();
        chk(busy == 1'b1, "R10 still busy after extra start", busy, 1);
        wait_done();
        repeat (120) @(posedge clk);
        @(negedge clk);
        chk(nrise == NBIT, "R10 rises with extra start", nrise, NBIT);
        chk(done_cnt == 1, "R10 one done with extra start", done_cnt, 1);
        check_script("ignored");
        chk(!busy, "R10 idle afterwards", busy, 0);
    endtask

    task automatic t_mid_reset();
        int r0;
        clear_mon();
        pulse_start();
        repeat (150) @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R1 mid-run reset busy/done", {busy, done}, 0);
        chk(!pclk && !pdat, "R1 mid-run reset clock/data", {pclk, pdat}, 0);
        r0 = nrise;
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(nrise == r0, "R1 no clocks after reset", nrise - r0, 0);
    endtask

    initial begin
        exp_code = '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'hC,
                     4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'hC, 4'h0};
        exp_word = '{16'h0E3C, 16'h6EF8, 16'h0E00, 16'h6EF7, 16'h0E05, 16'h6EF6, 16'h0101,
                     16'h0E3C, 16'h6EF8, 16'h0E00, 16'h6EF7, 16'h0E04, 16'h6EF6, 16'h8080,
                     16'h0000};
        t_reset();
        t_full_run();
        t_start_ignored();
        t_mid_reset();
        t_full_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog R2 run did not finish actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule